// File: doc/BRIEF.md
# Quiet Floating-Point Comparator

This block compares two IEEE-754 operands and returns a predicate. It handles both 32-bit and 64-bit formats. Three relations are available: equality, strictly greater, and greater-or-equal. It is purely combinational, so the predicate is valid in the same cycle as the operands and the operation code. A caller gets less-than or less-or-equal by exchanging the two operands.

The comparison is quiet: no input raises an exception flag. A quiet NaN, a signalling NaN and an ordered relation against a NaN all leave the flag vector at zero. Any NaN operand makes the pair unordered, and an unordered pair fails every relation.

Inside, each operand is classified in both formats. The classification picked by the precision select feeds an ordering stage. That stage resolves the pair to one of four named outcomes:

- `ORD_LESS`
- `ORD_EQUAL`
- `ORD_GREATER`
- `ORD_UNORDERED`

A decision stage maps the outcome and the operation code to the predicate byte.

There are no states and no transitions. The whole path from operands to predicate is combinational.

Top module: `quiet_fcmp`

## Requirements
- R1: With op code 0 (equal), the predicate is 0xFF exactly when both operands are non-NaN and hold the same value, and 0x00 otherwise.
- R2: With op code 1 (greater), the predicate is 0xFF exactly when both operands are non-NaN and operand A is strictly greater than operand B.
- R3: With op code 2 (greater-or-equal), the predicate is 0xFF exactly when both operands are non-NaN and A is greater than or equal to B.
- R4: If either operand is a NaN, the predicate is 0x00 for every op code. A NaN has an all-ones exponent and a non-zero fraction, whether its fraction MSB is set or clear.
- R5: The 5-bit flag output is zero for every input, including NaN operands under ordered relations.
- R6: The predicate is always either 0xFF (true) or 0x00 (false).
- R7: +0 and -0 are equal: equal and greater-or-equal are true for them, and greater is false.
- R8: Ordering follows sign and magnitude. A positive non-zero value exceeds any negative value. Between two negative values, the one with the larger magnitude is the smaller.
- R9: Infinities order as extreme values. +Inf exceeds the largest finite value, -Inf is below every finite value, and an infinity equals itself.
- R10: With the precision select at 0 (single), only bits 31:0 of each operand bus take part. Bits 63:32 have no effect on the result.
- R11: Op code 3 is reserved and always gives predicate 0x00.
- R12: The quiet NaN patterns 0x7FC00000 (single) and 0x7FF8000000000000 (double) are detected as NaN. So are the signalling patterns 0x7F800001 and 0x7FF7000000000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 64 | Operand A; in single mode only bits 31:0 are used |
| opb_i | input | 64 | Operand B; in single mode only bits 31:0 are used |
| dbl_i | input | 1 | Precision select: 1 = 64-bit format, 0 = 32-bit format |
| op_i | input | 2 | Relation: 0 equal, 1 greater, 2 greater-or-equal, 3 reserved |
| pred_o | output | 8 | Predicate byte, 0xFF true or 0x00 false |
| flags_o | output | 5 | Exception flags, always zero |

## Verification
The block holds no state, so a fault in its internal ordering outcome appears on `pred_o` in the same cycle as the operands that provoke it. Nothing is stored that a later vector could expose.

A wrong outcome shows up in different places depending on where it is wrong:
- A misread sign or a missing reversal for negative pairs flips the result only for mixed-sign or all-negative pairs.
- A NaN mis-detection shows only when the fraction MSB is clear (signalling patterns) or when the exponent is all ones.
- A wrong precision mux shows only when the upper halves of the buses carry junk in single mode.

The vector table therefore pairs each ordering outcome with every relation that can observe it.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    // widest format: 64-bit, magnitude excludes the sign bit
    localparam int BUS_W   = 64;
    localparam int MAG_W   = BUS_W - 1;
    localparam int PRED_W  = 8;
    localparam int FLAG_W  = 5;

    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;

    typedef enum logic [1:0] {
        CMP_EQ   = 2'd0,
        CMP_GT   = 2'd1,
        CMP_GE   = 2'd2,
        CMP_RSVD = 2'd3
    } cmp_op_e;

    typedef enum logic [1:0] {
        ORD_LESS      = 2'd0,
        ORD_EQUAL     = 2'd1,
        ORD_GREATER   = 2'd2,
        ORD_UNORDERED = 2'd3
    } cmp_ord_e;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             zero;
        logic [MAG_W-1:0] mag;
    } opnd_cls_t;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] bits_i,
    output opnd_cls_t            cls_o
);

    localparam int FMT_W = EXP_W + MAN_W + 1;

    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] frac;

    assign expo = bits_i[FMT_W-2 -: EXP_W];
    assign frac = bits_i[MAN_W-1:0];

    always_comb begin
        cls_o      = '0;
        cls_o.sign = bits_i[FMT_W-1];
        cls_o.nan  = (&expo) && (|frac);
        cls_o.zero = ~|bits_i[FMT_W-2:0];
        cls_o.mag[FMT_W-2:0] = bits_i[FMT_W-2:0];
    end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  opnd_cls_t a_i,
    input  opnd_cls_t b_i,
    output cmp_ord_e  ord_o
);

    logic mag_eq;
    logic mag_gt;

    assign mag_eq = (a_i.mag == b_i.mag);
    assign mag_gt = (a_i.mag >  b_i.mag);

    always_comb begin
        if (a_i.nan || b_i.nan) begin
            ord_o = ORD_UNORDERED;
        end else if (a_i.zero && b_i.zero) begin
            ord_o = ORD_EQUAL;
        end else if (a_i.sign != b_i.sign) begin
            ord_o = a_i.sign ? ORD_LESS : ORD_GREATER;
        end else if (mag_eq) begin
            ord_o = ORD_EQUAL;
        end else if (mag_gt) begin
            // larger magnitude wins for positives, loses for negatives
            ord_o = a_i.sign ? ORD_LESS : ORD_GREATER;
        end else begin
            ord_o = a_i.sign ? ORD_GREATER : ORD_LESS;
        end
    end

endmodule

// File: rtl/fpcmp_decide.sv
module fpcmp_decide
    import fpcmp_pkg::*;
(
    input  logic [1:0]        op_i,
    input  cmp_ord_e          ord_i,
    output logic [PRED_W-1:0] pred_o
);

    cmp_op_e op;
    logic    hit;

    assign op = cmp_op_e'(op_i);

    always_comb begin
        unique case (op)
            CMP_EQ:   hit = (ord_i == ORD_EQUAL);
            CMP_GT:   hit = (ord_i == ORD_GREATER);
            CMP_GE:   hit = (ord_i == ORD_GREATER) || (ord_i == ORD_EQUAL);
            CMP_RSVD: hit = 1'b0;
            default:  hit = 1'b0;
        endcase
    end

    assign pred_o = {PRED_W{hit}};

endmodule

// File: rtl/quiet_fcmp.sv
module quiet_fcmp
    import fpcmp_pkg::*;
(
    input  logic [BUS_W-1:0]  opa_i,
    input  logic [BUS_W-1:0]  opb_i,
    input  logic              dbl_i,
    input  logic [1:0]        op_i,
    output logic [PRED_W-1:0] pred_o,
    output logic [FLAG_W-1:0] flags_o
);

    localparam int NUM_OPND = 2;
    localparam int SP_W     = SP_EXP_W + SP_MAN_W + 1;
    localparam int DP_W     = DP_EXP_W + DP_MAN_W + 1;

    logic [BUS_W-1:0] bus [NUM_OPND];
    opnd_cls_t        cls [NUM_OPND];
    cmp_ord_e         ord;

    assign bus[0] = opa_i;
    assign bus[1] = opb_i;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        opnd_cls_t sp_cls;
        opnd_cls_t dp_cls;

        fpcmp_classify #(
            .EXP_W (SP_EXP_W),
            .MAN_W (SP_MAN_W)
        ) u_sp (
            .bits_i (bus[g][SP_W-1:0]),
            .cls_o  (sp_cls)
        );

        fpcmp_classify #(
            .EXP_W (DP_EXP_W),
            .MAN_W (DP_MAN_W)
        ) u_dp (
            .bits_i (bus[g][DP_W-1:0]),
            .cls_o  (dp_cls)
        );

        assign cls[g] = dbl_i ? dp_cls : sp_cls;
    end

    fpcmp_order u_order (
        .a_i   (cls[0]),
        .b_i   (cls[1]),
        .ord_o (ord)
    );

    fpcmp_decide u_decide (
        .op_i   (op_i),
        .ord_i  (ord),
        .pred_o (pred_o)
    );

    // comparisons are quiet: nothing is ever signalled
    assign flags_o = '0;

endmodule

// File: rtl/fpcmp_checker.sv
module fpcmp_checker
    import fpcmp_pkg::*;
(
    input logic [BUS_W-1:0]  opa_i,
    input logic [BUS_W-1:0]  opb_i,
    input logic              dbl_i,
    input logic [1:0]        op_i,
    input logic [PRED_W-1:0] pred_o,
    input logic [FLAG_W-1:0] flags_o
);

    logic a_nan, b_nan, a_zero, b_zero, same_bits;

    always_comb begin
        if (dbl_i) begin
            a_nan     = (opa_i[62:52] == 11'h7FF) && (opa_i[51:0] != '0);
            b_nan     = (opb_i[62:52] == 11'h7FF) && (opb_i[51:0] != '0);
            a_zero    = (opa_i[62:0] == '0);
            b_zero    = (opb_i[62:0] == '0);
            same_bits = (opa_i == opb_i);
        end else begin
            a_nan     = (opa_i[30:23] == 8'hFF) && (opa_i[22:0] != '0);
            b_nan     = (opb_i[30:23] == 8'hFF) && (opb_i[22:0] != '0);
            a_zero    = (opa_i[30:0] == '0);
            b_zero    = (opb_i[30:0] == '0);
            same_bits = (opa_i[31:0] == opb_i[31:0]);
        end
    end

    always_comb begin
        p_flags_quiet_r5: assert (flags_o == '0);
        p_pred_byte_r6:   assert (pred_o == 8'h00 || pred_o == 8'hFF);
        if (a_nan || b_nan)
            p_nan_false_r4: assert (pred_o == 8'h00);
        if (op_i == 2'd3)
            p_rsvd_false_r11: assert (pred_o == 8'h00);
        if (a_zero && b_zero && op_i != 2'd1 && op_i != 2'd3)
            p_zero_equal_r7: assert (pred_o == 8'hFF);
        if (same_bits && !a_nan && op_i == 2'd0)
            p_self_equal_r1: assert (pred_o == 8'hFF);
    end

endmodule

bind quiet_fcmp fpcmp_checker u_fpcmp_checker (
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .dbl_i   (dbl_i),
    .op_i    (op_i),
    .pred_o  (pred_o),
    .flags_o (flags_o)
);

// File: tb/quiet_fcmp_bench.sv
module quiet_fcmp_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] opa, opb;
    logic        dbl;
    logic [1:0]  op;
    logic [7:0]  pred;
    logic [4:0]  flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    quiet_fcmp u_quiet_fcmp (
        .opa_i   (opa),
        .opb_i   (opb),
        .dbl_i   (dbl),
        .op_i    (op),
        .pred_o  (pred),
        .flags_o (flags)
    );

    // vector layout: {dbl, op, a, b, expected predicate}
    localparam int NV = 33;
    localparam logic [138:0] VEC [NV] = '{
        {1'b0, 2'd0, 64'h3F800000, 64'h3F800000, 8'hFF},   // R1 1==1
        {1'b0, 2'd0, 64'h3F800000, 64'h40000000, 8'h00},   // R1 1==2
        {1'b0, 2'd1, 64'h40000000, 64'h3F800000, 8'hFF},   // R2 2>1
        {1'b0, 2'd1, 64'h3F800000, 64'h40000000, 8'h00},   // R2 1>2
        {1'b0, 2'd1, 64'h3F800000, 64'h3F800000, 8'h00},   // R2 1>1
        {1'b0, 2'd2, 64'h3F800000, 64'h3F800000, 8'hFF},   // R3 1>=1
        {1'b0, 2'd2, 64'h3F800000, 64'h40000000, 8'h00},   // R3 1>=2
        {1'b0, 2'd2, 64'h40000000, 64'h3F800000, 8'hFF},   // R3 2>=1
        {1'b0, 2'd1, 64'hBF800000, 64'hC0000000, 8'hFF},   // R8 -1>-2
        {1'b0, 2'd1, 64'hC0000000, 64'hBF800000, 8'h00},   // R8 -2>-1
        {1'b0, 2'd1, 64'h3F800000, 64'hC0000000, 8'hFF},   // R8 1>-2
        {1'b0, 2'd2, 64'hC0000000, 64'h3F800000, 8'h00},   // R8 -2>=1
        {1'b0, 2'd0, 64'h00000000, 64'h80000000, 8'hFF},   // R7 +0==-0
        {1'b0, 2'd1, 64'h00000000, 64'h80000000, 8'h00},   // R7 +0>-0
        {1'b0, 2'd2, 64'h80000000, 64'h00000000, 8'hFF},   // R7 -0>=+0
        {1'b0, 2'd1, 64'h7F800000, 64'h7F7FFFFF, 8'hFF},   // R9 +Inf>max
        {1'b0, 2'd1, 64'hFF800000, 64'hC0000000, 8'h00},   // R9 -Inf>-2
        {1'b0, 2'd0, 64'h7F800000, 64'h7F800000, 8'hFF},   // R9 Inf==Inf
        {1'b0, 2'd0, 64'h7FC00000, 64'h3F800000, 8'h00},   // R4 R12 qNaN==1
        {1'b0, 2'd1, 64'h7FC00000, 64'h3F800000, 8'h00},   // R4 qNaN>1
        {1'b0, 2'd2, 64'h3F800000, 64'h7FC00000, 8'h00},   // R4 1>=qNaN
        {1'b0, 2'd0, 64'h7FC00000, 64'h7FC00000, 8'h00},   // R4 qNaN==qNaN
        {1'b0, 2'd2, 64'h7F800001, 64'hFF800000, 8'h00},   // R12 sNaN>=-Inf
        {1'b1, 2'd0, 64'h3FF0000000000000, 64'h3FF0000000000000, 8'hFF}, // R1 dp
        {1'b1, 2'd0, 64'h3FF0000000000001, 64'h3FF0000000000000, 8'h00}, // R1 dp lsb
        {1'b1, 2'd1, 64'h4000000000000000, 64'h3FF0000000000000, 8'hFF}, // R2 dp
        {1'b1, 2'd2, 64'h3FF0000000000000, 64'h4000000000000000, 8'h00}, // R3 dp
        {1'b1, 2'd1, 64'hBFF0000000000000, 64'hC000000000000000, 8'hFF}, // R8 dp
        {1'b1, 2'd0, 64'h7FF8000000000000, 64'h3FF0000000000000, 8'h00}, // R12 dp qNaN
        {1'b1, 2'd2, 64'h7FF7000000000000, 64'h3FF0000000000000, 8'h00}, // R12 dp sNaN
        {1'b1, 2'd1, 64'h7FF8000000000000, 64'h7FF8000000000000, 8'h00}, // R4 dp
        {1'b1, 2'd2, 64'h7FF0000000000000, 64'h7FEFFFFFFFFFFFFF, 8'hFF}, // R9 dp
        {1'b0, 2'd3, 64'h3F800000, 64'h3F800000, 8'h00}    // R11 reserved
    };

    task automatic apply(input logic d, input logic [1:0] o,
                         input logic [63:0] a, input logic [63:0] b);
        @(posedge clk);
        #1;
        dbl = d; op = o; opa = a; opb = b;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] exp_pred);
        n_chk++;
        if (pred !== exp_pred) begin
            n_bad++;
            $display("FAIL %s pred actual=%h expected=%h", tag, pred, exp_pred);
        end
        n_chk++;
        if (flags !== 5'd0) begin
            n_bad++;
            $display("FAIL R5 flags actual=%h expected=00 (%s)", flags, tag);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        opa = '0; opb = '0; dbl = 1'b0; op = 2'd0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("reset R7 zero==zero", 8'hFF);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][138], VEC[i][137:136], VEC[i][135:72], VEC[i][71:8]);
            check($sformatf("vector %0d", i), VEC[i][7:0]);
        end

        // R10: junk upper halves in single mode
        apply(1'b0, 2'd0, {32'hDEADBEEF, 32'h3F800000}, {32'h12345678, 32'h3F800000});
        check("R10 junk high eq", 8'hFF);
        apply(1'b0, 2'd1, {32'h7FF80000, 32'h40000000}, {32'h00000000, 32'h3F800000});
        check("R10 nan-like high gt", 8'hFF);
        apply(1'b0, 2'd1, {32'h00000000, 32'h3F800000}, {32'hFFFFFFFF, 32'h3F800000});
        check("R10 high b ignored", 8'h00);
        // R6: same pair through every op code
        for (int k = 0; k < 4; k++) begin
            apply(1'b1, k[1:0], 64'hC000000000000000, 64'hC000000000000000);
            check("R6 byte all ops", (k == 0 || k == 2) ? 8'hFF : 8'h00);
        end
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            finish_run();
        end
    end

endmodule